// File: doc/BRIEF.md
# Shared External Bus Ownership Arbiter

This block decides, for one processor node, who drives a shared external memory bus: the node itself, one peer node on the same bus, or an external host. Each node gets a two-bit identity that picks which of two bus-request wires it drives. The other wire is only watched. Identity zero means the node is alone, so no peer arbitration takes place.

Ownership between peers is tracked by a parked-master scheme. The last owner keeps the bus until its request wire falls. It only lets that wire fall when it has no access in progress, so no transfer is cut off partway.

A host request overrides peer arbitration. The current master hands the bus to the host and raises the host grant. While the host holds the bus, or while an external suspend input is active, the address, data, select and strobe drivers are switched off. The SDRAM control drivers keep running. Local accesses that cannot reach the bus stall the core.

A host-facing ready signal tells the host to wait until it holds the bus. It can be wired open-drain or actively driven.

Top module: `bus_own_arb`

## Requirements
- R1: Node identity 2'b01 enables only request wire 0 (`bus_req_oe_o` = 2'b01). Identity 2'b10 enables only wire 1 (2'b10). Identity 2'b00 enables neither wire, and the node always owns the bus when no host holds it. At most one request wire is ever enabled.
- R2: The driven request wire follows `core_req_i` one clock later.
- R3: When a host request and a peer request are both pending, the host is served first. Peer ownership does not change while the host request or the host grant is active.
- R4: The host grant rises three clocks after the host request rises at an idle master (two synchronizer flops plus one state flop). It stays high while the request stays high, and falls three clocks after the request is withdrawn.
- R5: While the host grant is high, the address, data, select and strobe enables are low and the SDRAM control enable stays high.
- R6: The clock after `suspend_i` is sampled high, the address, data, select and strobe enables are low. The SDRAM control enable is unaffected. The enables return one clock after suspend is removed.
- R7: `core_stall_o` is high whenever `core_req_i` is high and either `suspend_i` is high, suspend was high on the previous clock, or the node does not own the bus. It clears one clock after suspend is removed.
- R8: `rdy_oe_o` is only ever high while both `host_cs_i` and `host_req_i` are high. Ready is high only once the host holds the grant. With `cfg_rdy_active_i` = 0 (open-drain), `rdy_o` is always 0 and the enable is on only while ready is low. With `cfg_rdy_active_i` = 1, the enable is on for the whole selected window and `rdy_o` carries ready.
- R9: `hgrant_oe_o` is high only on the node that is bus master. Non-masters leave the grant undriven.
- R10: A master with `core_req_i` high keeps the bus even while the peer wire is high.
- R11: A non-master takes the bus once its own request is up and the peer wire has been low through the synchronizer. Until then its core is stalled.
- R12: While suspend is active, the master hands the bus to a requesting host even if a local access is pending.
- R13: The identity is captured once, on the first clock after reset. Later changes on `node_id_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| node_id_i | input | 2 | Node identity, captured after reset |
| cfg_rdy_active_i | input | 1 | 1 = ready actively driven, 0 = open-drain |
| bus_req_i | input | 2 | Observed levels of the two bus-request wires |
| bus_req_o | output | 2 | Value driven onto the request wires |
| bus_req_oe_o | output | 2 | Per-wire drive enable |
| host_req_i | input | 1 | Host bus request |
| host_cs_i | input | 1 | Host chip select |
| hgrant_o | output | 1 | Host grant value |
| hgrant_oe_o | output | 1 | Host grant drive enable |
| suspend_i | input | 1 | Suspend bus drive |
| core_req_i | input | 1 | Local core external access request |
| core_stall_o | output | 1 | Stall to the local core |
| addr_oe_o | output | 1 | Address driver enable |
| data_oe_o | output | 1 | Data driver enable |
| sel_oe_o | output | 1 | Memory select driver enable |
| strb_oe_o | output | 1 | Strobe driver enable |
| sdram_oe_o | output | 1 | SDRAM control driver enable |
| rdy_o | output | 1 | Host ready value |
| rdy_oe_o | output | 1 | Host ready drive enable |

## Verification
The bench targets several ordering hazards.

- Host and peer requests arriving on the same clock: a design without host priority would hand the bus to the peer and leave the host waiting.
- A peer requesting while the master is mid-access: a premature handover would drop the address drivers under a running transfer.
- The deadlock case of a stalled local access facing a host request: a design that ignored suspend would never grant.
- The exact clock on which suspend floats the pins.
- The full select-by-mode grid of the ready output: open-drain and active-drive confused would drive the ready wire high in open-drain mode.

// File: rtl/bus_own_pkg.sv
package bus_own_pkg;
  localparam int unsigned REQ_LINES = 2;
  localparam int unsigned ID_W      = 2;
  localparam int unsigned PIN_GRPS  = 4;

  typedef enum logic [1:0] {
    GRP_ADDR = 2'd0,
    GRP_DATA = 2'd1,
    GRP_SEL  = 2'd2,
    GRP_STRB = 2'd3
  } pin_grp_e;

  localparam logic [ID_W-1:0] ID_SOLO  = 2'b00;
  localparam logic [ID_W-1:0] ID_LINE0 = 2'b01;
  localparam logic [ID_W-1:0] ID_LINE1 = 2'b10;
endpackage

// File: rtl/bus_own_sync.sv
module bus_own_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/bus_own_peer.sv
module bus_own_peer
  import bus_own_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ID_W-1:0]      node_id_i,
  input  logic [REQ_LINES-1:0] req_sync_i,
  input  logic                 core_req_i,
  input  logic                 host_hold_i,
  output logic                 is_master_o,
  output logic [REQ_LINES-1:0] req_o,
  output logic [REQ_LINES-1:0] req_oe_o
);
  logic            run_q, run_d;
  logic [ID_W-1:0] id_q, id_d;
  logic            own_req_q, own_req_d;
  logic            master_q, master_d;
  logic            solo, own_idx, other_idx, other_s, id_en;

  assign solo      = (id_q != ID_LINE0) && (id_q != ID_LINE1);
  assign own_idx   = (id_q == ID_LINE1);
  assign other_idx = ~own_idx;
  assign other_s   = req_sync_i[other_idx];
  assign id_en     = ~run_q;

  always_comb begin
    run_d     = 1'b1;
    id_d      = id_en ? node_id_i : id_q;
    own_req_d = core_req_i & ~solo;
    master_d  = master_q;
    if (run_q && !solo && !host_hold_i) begin
      if (master_q == own_idx) begin
        if (!own_req_q && other_s) master_d = other_idx;
      end else begin
        if (!other_s && own_req_q) master_d = own_idx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      id_q      <= ID_SOLO;
      own_req_q <= 1'b0;
      master_q  <= 1'b0;
    end else begin
      run_q     <= run_d;
      id_q      <= id_d;
      own_req_q <= own_req_d;
      master_q  <= master_d;
    end
  end

  assign is_master_o = run_q & (solo | (master_q == own_idx));

  for (genvar l = 0; l < REQ_LINES; l++) begin : g_line
    assign req_oe_o[l] = run_q & ~solo & (own_idx == l[0]);
    assign req_o[l]    = req_oe_o[l] & own_req_q;
  end
endmodule

// File: rtl/bus_own_host.sv
module bus_own_host (
  input  logic clk,
  input  logic rst_n,
  input  logic hreq_sync_i,
  input  logic host_req_i,
  input  logic host_cs_i,
  input  logic cfg_rdy_active_i,
  input  logic is_master_i,
  input  logic core_req_i,
  input  logic susp_q_i,
  output logic granted_o,
  output logic host_hold_o,
  output logic hgrant_oe_o,
  output logic rdy_o,
  output logic rdy_oe_o
);
  logic granted_q, granted_d;
  logic core_quiet, rdy_sel, rdy_val;

  assign core_quiet = ~core_req_i | susp_q_i;

  always_comb begin
    if (granted_q) granted_d = hreq_sync_i;
    else           granted_d = hreq_sync_i & is_master_i & core_quiet;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) granted_q <= 1'b0;
    else        granted_q <= granted_d;
  end

  assign granted_o   = granted_q;
  assign host_hold_o = hreq_sync_i | granted_q;
  assign hgrant_oe_o = is_master_i;

  assign rdy_sel  = host_cs_i & host_req_i;
  assign rdy_val  = granted_q;
  assign rdy_oe_o = rdy_sel & (cfg_rdy_active_i | ~rdy_val);
  assign rdy_o    = rdy_sel & cfg_rdy_active_i & rdy_val;
endmodule

// File: rtl/bus_own_pins.sv
module bus_own_pins
  import bus_own_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                is_master_i,
  input  logic                granted_i,
  input  logic                suspend_i,
  input  logic                core_req_i,
  output logic                susp_q_o,
  output logic [PIN_GRPS-1:0] grp_oe_o,
  output logic                sdram_oe_o,
  output logic                stall_o
);
  logic susp_q;
  logic own_bus;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) susp_q <= 1'b0;
    else        susp_q <= suspend_i;
  end

  assign own_bus = is_master_i & ~granted_i;

  for (genvar g = 0; g < PIN_GRPS; g++) begin : g_grp
    assign grp_oe_o[g] = own_bus & ~susp_q;
  end

  assign sdram_oe_o = is_master_i;
  assign stall_o    = core_req_i & (~own_bus | suspend_i | susp_q);
  assign susp_q_o   = susp_q;
endmodule

// File: rtl/bus_own_arb.sv
module bus_own_arb
  import bus_own_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] node_id_i,
  input  logic       cfg_rdy_active_i,
  input  logic [1:0] bus_req_i,
  output logic [1:0] bus_req_o,
  output logic [1:0] bus_req_oe_o,
  input  logic       host_req_i,
  input  logic       host_cs_i,
  output logic       hgrant_o,
  output logic       hgrant_oe_o,
  input  logic       suspend_i,
  input  logic       core_req_i,
  output logic       core_stall_o,
  output logic       addr_oe_o,
  output logic       data_oe_o,
  output logic       sel_oe_o,
  output logic       strb_oe_o,
  output logic       sdram_oe_o,
  output logic       rdy_o,
  output logic       rdy_oe_o
);
  localparam int unsigned SYNC_W = REQ_LINES + 1;

  logic [SYNC_W-1:0]   sync_out;
  logic                is_master, granted, host_hold, susp_q;
  logic [PIN_GRPS-1:0] grp_oe;

  bus_own_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({host_req_i, bus_req_i}),
    .dout (sync_out)
  );

  bus_own_peer u_peer (
    .clk        (clk),
    .rst_n      (rst_n),
    .node_id_i  (node_id_i),
    .req_sync_i (sync_out[REQ_LINES-1:0]),
    .core_req_i (core_req_i),
    .host_hold_i(host_hold),
    .is_master_o(is_master),
    .req_o      (bus_req_o),
    .req_oe_o   (bus_req_oe_o)
  );

  bus_own_host u_host (
    .clk             (clk),
    .rst_n           (rst_n),
    .hreq_sync_i     (sync_out[REQ_LINES]),
    .host_req_i      (host_req_i),
    .host_cs_i       (host_cs_i),
    .cfg_rdy_active_i(cfg_rdy_active_i),
    .is_master_i     (is_master),
    .core_req_i      (core_req_i),
    .susp_q_i        (susp_q),
    .granted_o       (granted),
    .host_hold_o     (host_hold),
    .hgrant_oe_o     (hgrant_oe_o),
    .rdy_o           (rdy_o),
    .rdy_oe_o        (rdy_oe_o)
  );

  bus_own_pins u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .is_master_i(is_master),
    .granted_i  (granted),
    .suspend_i  (suspend_i),
    .core_req_i (core_req_i),
    .susp_q_o   (susp_q),
    .grp_oe_o   (grp_oe),
    .sdram_oe_o (sdram_oe_o),
    .stall_o    (core_stall_o)
  );

  assign hgrant_o  = granted;
  assign addr_oe_o = grp_oe[GRP_ADDR];
  assign data_oe_o = grp_oe[GRP_DATA];
  assign sel_oe_o  = grp_oe[GRP_SEL];
  assign strb_oe_o = grp_oe[GRP_STRB];
endmodule

// File: rtl/bus_own_arb_chk.sv
module bus_own_arb_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] bus_req_oe_o,
  input logic       host_req_i,
  input logic       host_cs_i,
  input logic       cfg_rdy_active_i,
  input logic       hgrant_o,
  input logic       hgrant_oe_o,
  input logic       suspend_i,
  input logic       core_req_i,
  input logic       core_stall_o,
  input logic       addr_oe_o,
  input logic       data_oe_o,
  input logic       sel_oe_o,
  input logic       strb_oe_o,
  input logic       sdram_oe_o,
  input logic       rdy_o,
  input logic       rdy_oe_o
);
  assert_one_wire_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_req_oe_o));

  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hgrant_o |-> (!addr_oe_o && !data_oe_o && !sel_oe_o && !strb_oe_o && sdram_oe_o));

  assert_suspend_float_R6: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_i |=> (!addr_oe_o && !data_oe_o && !sel_oe_o && !strb_oe_o));

  assert_suspend_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (suspend_i && core_req_i) |-> core_stall_o);

  assert_ready_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_oe_o |-> (host_cs_i && host_req_i));

  assert_open_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdy_active_i |-> !rdy_o);

  assert_grant_driver_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hgrant_o |-> hgrant_oe_o);
endmodule

bind bus_own_arb bus_own_arb_chk u_chk (.*);

// File: tb/bus_own_arb_test.sv
module bus_own_arb_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] node_id_i;
  logic       cfg_rdy_active_i;
  logic [1:0] bus_req_i;
  logic [1:0] bus_req_o, bus_req_oe_o;
  logic       host_req_i, host_cs_i, hgrant_o, hgrant_oe_o;
  logic       suspend_i, core_req_i, core_stall_o;
  logic       addr_oe_o, data_oe_o, sel_oe_o, strb_oe_o, sdram_oe_o;
  logic       rdy_o, rdy_oe_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  bus_own_arb uut (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] bus_oes();
    return {3'b0, sdram_oe_o, strb_oe_o, sel_oe_o, data_oe_o, addr_oe_o};
  endfunction

  task automatic do_reset(input logic [1:0] id);
    @(negedge clk);
    rst_n = 1'b0; node_id_i = id; cfg_rdy_active_i = 1'b0; bus_req_i = '0;
    host_req_i = 1'b0; host_cs_i = 1'b0; suspend_i = 1'b0; core_req_i = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(2);
  endtask

  initial begin
    int wd = 0;
    while (!done && wd < 20000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1 / R9: reset state across every legal identity
    for (int id = 0; id < 3; id++) begin
      logic own;
      do_reset(id[1:0]);
      own = (id != 2);
      check("R1 req oe", {6'b0, bus_req_oe_o}, (id == 0) ? 8'h00 : (id == 1) ? 8'h01 : 8'h02);
      check("R9 grant oe", {7'b0, hgrant_oe_o}, {7'b0, own});
      check("R1 bus oe", bus_oes(), own ? 8'h1f : 8'h00);
    end

    // R13: identity frozen after capture
    do_reset(2'b01);
    node_id_i = 2'b10;
    tick(3);
    check("R13 id frozen", {6'b0, bus_req_oe_o}, 8'h01);

    // R2: request wire follows core one clock later
    core_req_i = 1'b1;
    #1 check("R2 not yet", {6'b0, bus_req_o}, 8'h00);
    tick(1);
    check("R2 raised", {6'b0, bus_req_o}, 8'h01);
    check("R7 master no stall", {7'b0, core_stall_o}, 8'h00);

    // R10: master with access in progress keeps bus
    bus_req_i[1] = 1'b1;
    tick(5);
    check("R10 holds bus", bus_oes(), 8'h1f);
    core_req_i = 1'b0;
    tick(1);
    check("R2 dropped", {6'b0, bus_req_o}, 8'h00);
    tick(2);
    check("R10 handed over", bus_oes(), 8'h00);
    check("R9 non-master grant oe", {7'b0, hgrant_oe_o}, 8'h00);

    // R11: non-master stalls, then takes bus after peer releases
    core_req_i = 1'b1;
    #1 check("R11 stall", {7'b0, core_stall_o}, 8'h01);
    bus_req_i[1] = 1'b0;
    tick(4);
    check("R11 no stall", {7'b0, core_stall_o}, 8'h00);
    check("R11 owns", bus_oes(), 8'h1f);
    core_req_i = 1'b0;

    // R3 / R4 / R5: host and peer request together
    do_reset(2'b01);
    bus_req_i[1] = 1'b1; host_req_i = 1'b1;
    tick(2);
    check("R4 grant latency early", {7'b0, hgrant_o}, 8'h00);
    tick(1);
    check("R4 grant latency", {7'b0, hgrant_o}, 8'h01);
    check("R3 host first, grant oe", {7'b0, hgrant_oe_o}, 8'h01);
    check("R5 float keep sdram", bus_oes(), 8'h10);
    tick(5);
    check("R4 grant held", {7'b0, hgrant_o}, 8'h01);
    host_req_i = 1'b0;
    tick(2);
    check("R4 grant still", {7'b0, hgrant_o}, 8'h01);
    tick(1);
    check("R4 grant dropped", {7'b0, hgrant_o}, 8'h00);
    tick(3);
    check("R3 peer after host", bus_oes(), 8'h00);
    bus_req_i[1] = 1'b0;

    // R6 / R7: suspend in single-node mode
    do_reset(2'b00);
    core_req_i = 1'b1; suspend_i = 1'b1;
    #1 check("R7 stall now", {7'b0, core_stall_o}, 8'h01);
    check("R6 same cycle driven", bus_oes(), 8'h1f);
    tick(1);
    check("R6 floated", bus_oes(), 8'h10);
    check("R7 stall held", {7'b0, core_stall_o}, 8'h01);
    suspend_i = 1'b0;
    tick(1);
    check("R6 restored", bus_oes(), 8'h1f);
    check("R7 stall cleared", {7'b0, core_stall_o}, 8'h00);
    core_req_i = 1'b0;

    // R12: suspend breaks host/core deadlock
    do_reset(2'b01);
    core_req_i = 1'b1; host_req_i = 1'b1;
    tick(6);
    check("R12 no grant during access", {7'b0, hgrant_o}, 8'h00);
    suspend_i = 1'b1;
    tick(2);
    check("R12 grant with suspend", {7'b0, hgrant_o}, 8'h01);
    host_req_i = 1'b0; suspend_i = 1'b0; core_req_i = 1'b0;

    // R8: ready sweep while not granted
    do_reset(2'b01);
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 2; c++) begin
        for (int h = 0; h < 2; h++) begin
          cfg_rdy_active_i = m[0]; host_cs_i = c[0]; host_req_i = h[0];
          #1;
          check("R8 wait oe", {7'b0, rdy_oe_o}, {7'b0, c[0] & h[0]});
          check("R8 wait val", {7'b0, rdy_o}, 8'h00);
          host_req_i = 1'b0;
          tick(4);
        end
      end
    end
    // R8: ready once granted
    host_req_i = 1'b1; host_cs_i = 1'b1;
    tick(4);
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 2; c++) begin
        cfg_rdy_active_i = m[0]; host_cs_i = c[0];
        #1;
        check("R8 ready oe", {7'b0, rdy_oe_o}, {7'b0, c[0] & m[0]});
        check("R8 ready val", {7'b0, rdy_o}, {7'b0, c[0] & m[0]});
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule